// File: doc/BRIEF.md
# Light-Sensor Measurement Sequencer

This block schedules light-to-digital conversions for an integrating light sensor. A command byte sets whether the block runs, whether it does one conversion or runs continuously, which photodiode (visible or infrared) the analog side uses, how an integration window is timed, and which of four gain ranges applies. The range and sensor-select bits go straight to the analog front end. The block counts pulses from the charge-balance modulator during each window and publishes the count as a 16-bit result.

A window is timed in one of two ways. With internal timing it lasts a fixed power-of-two number of oscillator ticks, chosen by a two-bit resolution code. With external timing it runs from one sync strobe to the next. In that mode a tick timer measures the window, and the published value is either the modulator count or the tick count. Each new result is loaded in one step and marked by a one-cycle update strobe. The result is a register, not a stream: it has no ready input and no back-pressure, and a reader takes it any time after the strobe. In one-shot operation the block powers itself down after one result and holds that result.

Top module: `lux_seq`

## Requirements
- R1: After reset `pwr_down` is 1, `result` is 0 and `result_upd` is 0.
- R2: A command write (`cmd_we` high for one cycle) takes effect at the next clock edge. With bit 7 = 0 the block powers down (`pwr_down` = 1) and publishes nothing, whatever ticks, pulses or strobes arrive. With bit 7 = 1 and a valid mode, `pwr_down` is 0.
- R3: Mode code bits 4:2 = 0b0rr selects internal timing. The window lasts 2^(16-4*rr) ticks of `osc_tick`, which is 65536, 4096, 256 or 16 for rr = 0, 1, 2, 3. The window opens after the command write. The result includes pulses up to and including the cycle of the final tick, and it appears one clock after that cycle.
- R4: With bit 6 = 0 (one-shot), after one result the block sets `pwr_down` = 1. The result then holds, and later ticks, pulses and strobes do not change it.
- R5: With bit 6 = 1 (continuous), windows follow each other back to back and each one publishes a new result, counted from zero, until another command arrives.
- R6: Mode code 0b100 (external, modulator count): the first `sync_stb` after the command opens a window and publishes nothing. Each later strobe publishes the modulator pulses counted since the previous strobe, and a new window opens at once. The result appears one clock after the strobe cycle.
- R7: Mode code 0b101 (external, timer): on each closing strobe the published value is the number of `osc_tick` cycles since the previous strobe.
- R8: The pulse counter and the tick timer stop at 65535 instead of wrapping.
- R9: Mode codes 0b110 and 0b111 keep `pwr_down` = 0 and publish nothing. The result is left unchanged.
- R10: `range_sel` equals command bits 1:0 and `ir_sel` equals command bit 5, from the clock edge that stores the command.
- R11: `result` changes only at the edge that raises `result_upd`, and `result_upd` lasts one cycle per published value.
- R12: A command write during a window discards the partial counts and restarts timing from the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command byte |
| osc_tick | input | 1 | One pulse per oscillator cycle |
| sync_stb | input | 1 | External window strobe |
| mod_pulse | input | 1 | Charge-balance modulator pulse |
| result | output | 16 | Latest published count |
| result_upd | output | 1 | One-cycle strobe marking a new result |
| pwr_down | output | 1 | Power-down request to the analog side |
| integrating | output | 1 | High while a window is counting |
| ir_sel | output | 1 | Infrared photodiode select |
| range_sel | output | 2 | Gain range passed to the front end |

## Verification
An internal window closes on the 2^n-th tick after the command write, and its result and strobe are due one clock after the cycle with that last tick. The bench drives ticks every cycle from the cycle after the write, so a strobe seen at sample index 2^n+1 matches the expected timing. An external result is due one clock after the closing strobe cycle, and the bench samples exactly there. Inputs are driven and outputs sampled on the falling edge, so each sample shows all rising-edge updates up to that point. Exact indices and single-strobe counts show any early, late or repeated publish.

// File: rtl/lux_seq_pkg.sv
package lux_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_INT  = 3'd1,
    ST_ARM  = 3'd2,
    ST_EXT  = 3'd3,
    ST_HOLD = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic       en;
    logic       cont;
    logic       ir;
    logic [2:0] mode;
    logic [1:0] rng;
  } cmd_t;

  localparam logic [2:0] MODE_EXT_ADC = 3'b100;
  localparam logic [2:0] MODE_EXT_TMR = 3'b101;

endpackage

// File: rtl/lux_sat_cnt.sv
module lux_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_comb begin
    nxt_o = cnt_o;
    if (inc_i && cnt_o != TOP) nxt_o = cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= nxt_o;
  end

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == TOP && !clr_i) |=> (cnt_o == TOP));

endmodule

// File: rtl/lux_seq_ctl.sv
module lux_seq_ctl
  import lux_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RES_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we_i,
  input  logic             new_en_i,
  input  logic [2:0]       new_mode_i,
  input  logic             cont_i,
  input  logic [1:0]       res_i,
  input  logic             osc_tick_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  output seq_state_t       state_o,
  output logic             win_end_o,
  output logic             clr_o,
  output logic             run_o
);

  seq_state_t state_q, state_d;

  function automatic logic [CNT_W-1:0] win_last(input logic [1:0] res);
    logic [63:0] one;
    int unsigned sh;
    one = 64'd1;
    sh  = CNT_W - RES_STEP * int'(res);
    return CNT_W'((one << sh) - one);
  endfunction

  function automatic seq_state_t decode(input logic en, input logic [2:0] mode);
    if (!en)                      return ST_OFF;
    else if (!mode[2])            return ST_INT;
    else if (mode == MODE_EXT_ADC || mode == MODE_EXT_TMR) return ST_ARM;
    else                          return ST_HOLD;
  endfunction

  always_comb begin
    state_d   = state_q;
    win_end_o = 1'b0;
    clr_o     = 1'b0;
    unique case (state_q)
      ST_INT:  if (osc_tick_i && tmr_cnt_i == win_last(res_i)) win_end_o = 1'b1;
      ST_EXT:  if (sync_i) win_end_o = 1'b1;
      ST_ARM:  if (sync_i) begin state_d = ST_EXT; clr_o = 1'b1; end
      default: ;
    endcase
    if (win_end_o) begin
      clr_o   = 1'b1;
      state_d = cont_i ? state_q : ST_OFF;
    end
    if (cmd_we_i) begin
      win_end_o = 1'b0;
      clr_o     = 1'b1;
      state_d   = decode(new_en_i, new_mode_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign run_o   = (state_q == ST_INT) || (state_q == ST_EXT);

  // R9
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> !win_end_o);

  // R6
  arm_no_publish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM) |-> !win_end_o);

  // R3
  int_end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INT && win_end_o) |-> osc_tick_i);

endmodule

// File: rtl/lux_seq.sv
module lux_seq
  import lux_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RES_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_wdata,
  input  logic             osc_tick,
  input  logic             sync_stb,
  input  logic             mod_pulse,
  output logic [CNT_W-1:0] result,
  output logic             result_upd,
  output logic             pwr_down,
  output logic             integrating,
  output logic             ir_sel,
  output logic [1:0]       range_sel
);

  cmd_t             cmd_q, cmd_w;
  seq_state_t       state;
  logic             win_end, clr, run;
  logic [CNT_W-1:0] tmr_cnt, tmr_nxt, adc_cnt, adc_nxt;

  assign cmd_w = cmd_t'(cmd_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= cmd_w;
  end

  lux_seq_ctl #(.CNT_W(CNT_W), .RES_STEP(RES_STEP)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we_i   (cmd_we),
    .new_en_i   (cmd_w.en),
    .new_mode_i (cmd_w.mode),
    .cont_i     (cmd_q.cont),
    .res_i      (cmd_q.mode[1:0]),
    .osc_tick_i (osc_tick),
    .sync_i     (sync_stb),
    .tmr_cnt_i  (tmr_cnt),
    .state_o    (state),
    .win_end_o  (win_end),
    .clr_o      (clr),
    .run_o      (run)
  );

  lux_sat_cnt #(.W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .inc_i (osc_tick & run),
    .cnt_o (tmr_cnt),
    .nxt_o (tmr_nxt)
  );

  lux_sat_cnt #(.W(CNT_W)) u_adc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .inc_i (mod_pulse & run),
    .cnt_o (adc_cnt),
    .nxt_o (adc_nxt)
  );

  logic sel_tmr;
  assign sel_tmr = (cmd_q.mode == MODE_EXT_TMR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      result_upd <= 1'b0;
    end else begin
      result_upd <= win_end;
      if (win_end) result <= sel_tmr ? tmr_nxt : adc_nxt;
    end
  end

  assign pwr_down    = (state == ST_OFF);
  assign integrating = run;
  assign ir_sel      = cmd_q.ir;
  assign range_sel   = cmd_q.rng;

  // R11
  result_only_on_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_upd |-> (result == $past(result)));

  // R4
  oneshot_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !cmd_q.cont) |=> pwr_down);

  // R2
  off_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !integrating);

endmodule

// File: tb/lux_seq_test.sv
`timescale 1ns/1ps
module lux_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_wdata = 8'h00;
  logic        osc_tick = 1'b0;
  logic        sync_stb = 1'b0;
  logic        mod_pulse = 1'b0;
  logic [15:0] result;
  logic        result_upd, pwr_down, integrating, ir_sel;
  logic [1:0]  range_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lux_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .osc_tick(osc_tick), .sync_stb(sync_stb), .mod_pulse(mod_pulse),
    .result(result), .result_upd(result_upd), .pwr_down(pwr_down),
    .integrating(integrating), .ir_sel(ir_sel), .range_sel(range_sel)
  );

  typedef struct packed {
    logic [7:0]  cmd;
    logic [1:0]  pat;
    logic [16:0] win;
    logic [15:0] exp;
    logic        pd;
  } vec_t;

  // pat: 1 = pulse every cycle, 2 = pulse on odd cycles
  localparam vec_t VECS [4] = '{
    '{cmd: 8'h8F, pat: 2'd1, win: 17'd16,    exp: 16'd16,    pd: 1'b1},
    '{cmd: 8'hCB, pat: 2'd2, win: 17'd256,   exp: 16'd128,   pd: 1'b0},
    '{cmd: 8'h84, pat: 2'd2, win: 17'd4096,  exp: 16'd2048,  pd: 1'b1},
    '{cmd: 8'hA1, pat: 2'd1, win: 17'd65536, exp: 16'd65535, pd: 1'b1}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] c);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = c;
    osc_tick = 1'b0; mod_pulse = 1'b0; sync_stb = 1'b0;
  endtask

  task automatic watch(input int n, input logic [1:0] pat,
                       output int first, output logic [15:0] val, output int nupd);
    first = -1; val = '0; nupd = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (result_upd) begin
        nupd++;
        if (first < 0) begin first = i; val = result; end
      end
      cmd_we = 1'b0; osc_tick = 1'b1; sync_stb = 1'b0;
      mod_pulse = (pat == 2'd1) ? 1'b1 : (pat == 2'd2) ? i[0] : 1'b0;
    end
  endtask

  task automatic noisy(input int n, output int nupd);
    nupd = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (result_upd) nupd++;
      cmd_we = 1'b0; osc_tick = 1'b1; mod_pulse = 1'b1;
      sync_stb = (i % 3 == 0);
    end
  endtask

  task automatic ext_win(input int n, input logic [1:0] pat,
                         output logic [15:0] val, output int early, output logic got);
    int f;
    watch(n, pat, f, val, early);
    @(negedge clk);
    if (result_upd) early++;
    osc_tick = 1'b0; mod_pulse = 1'b0; sync_stb = 1'b1;
    @(negedge clk);
    got = result_upd; val = result;
    sync_stb = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int first, nupd, early;
    logic [15:0] val;
    logic got;

    repeat (3) @(negedge clk);
    chk(pwr_down == 1'b1, "R1 pwr_down", int'(pwr_down), 1);
    chk(result == 16'd0, "R1 result", int'(result), 0);
    chk(result_upd == 1'b0, "R1 result_upd", int'(result_upd), 0);
    rst_n = 1'b1;

    // table of internal-timing windows
    foreach (VECS[k]) begin
      wr(VECS[k].cmd);
      watch(int'(VECS[k].win) + 2, VECS[k].pat, first, val, nupd);
      chk(first == int'(VECS[k].win) + 1, "R3 window length", first, int'(VECS[k].win) + 1);
      chk(val == VECS[k].exp, "R3/R8 count", int'(val), int'(VECS[k].exp));
      chk(nupd == 1, "R11 single strobe", nupd, 1);
      chk(pwr_down == VECS[k].pd, "R4/R5 power state", int'(pwr_down), int'(VECS[k].pd));
      chk(range_sel == VECS[k].cmd[1:0], "R10 range", int'(range_sel), int'(VECS[k].cmd[1:0]));
      chk(ir_sel == VECS[k].cmd[5], "R10 ir", int'(ir_sel), int'(VECS[k].cmd[5]));
    end

    // R4: one-shot holds result while powered down
    wr(8'h8F);
    watch(17, 2'd1, first, val, nupd);
    chk(val == 16'd16, "R4 one-shot result", int'(val), 16);
    noisy(40, nupd);
    chk(nupd == 0, "R4 no update after sleep", nupd, 0);
    chk(result == 16'd16, "R4 held result", int'(result), 16);
    chk(pwr_down == 1'b1, "R4 asleep", int'(pwr_down), 1);

    // R5: continuous, back-to-back windows
    wr(8'hCF);
    watch(34, 2'd1, first, val, nupd);
    chk(first == 17, "R5 first update", first, 17);
    chk(nupd == 2, "R5 two updates", nupd, 2);
    chk(result == 16'd16, "R5 restarted count", int'(result), 16);
    chk(pwr_down == 1'b0, "R5 stays awake", int'(pwr_down), 0);

    // R12: rewrite mid-window restarts
    wr(8'h8F);
    watch(10, 2'd1, first, val, nupd);
    chk(nupd == 0, "R12 no early publish", nupd, 0);
    wr(8'h8F);
    watch(17, 2'd1, first, val, nupd);
    chk(first == 17, "R12 restart timing", first, 17);
    chk(val == 16'd16, "R12 restart count", int'(val), 16);

    // R6: external modulator-count mode
    wr(8'hD0);
    ext_win(5, 2'd1, val, early, got);
    chk(got == 1'b0 && early == 0, "R6 arming strobe silent", int'(got), 0);
    ext_win(20, 2'd2, val, early, got);
    chk(got == 1'b1, "R6 strobe publishes", int'(got), 1);
    chk(val == 16'd10, "R6 pulse count", int'(val), 10);
    ext_win(6, 2'd1, val, early, got);
    chk(got == 1'b1 && val == 16'd6, "R6 next window", int'(val), 6);
    chk(pwr_down == 1'b0, "R6 continuous awake", int'(pwr_down), 0);

    // R7: external timer mode
    wr(8'hD4);
    ext_win(3, 2'd1, val, early, got);
    ext_win(37, 2'd1, val, early, got);
    chk(got == 1'b1 && val == 16'd37, "R7 tick count", int'(val), 37);

    // R8: timer saturation, one-shot external
    wr(8'h94);
    ext_win(1, 2'd0, val, early, got);
    ext_win(65600, 2'd0, val, early, got);
    chk(val == 16'hFFFF, "R8 timer saturates", int'(val), 65535);
    chk(pwr_down == 1'b1, "R4 external one-shot sleeps", int'(pwr_down), 1);

    // R9: reserved mode
    wr(8'h98);
    noisy(40, nupd);
    chk(pwr_down == 1'b0, "R9 powered", int'(pwr_down), 0);
    chk(nupd == 0, "R9 no update", nupd, 0);
    chk(result == 16'hFFFF, "R9 result kept", int'(result), 65535);

    // R2: disable bit clear
    wr(8'h4F);
    noisy(40, nupd);
    chk(pwr_down == 1'b1, "R2 powered down", int'(pwr_down), 1);
    chk(nupd == 0, "R2 no update when off", nupd, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule